// File: doc/BRIEF.md
# Statistics counter update engine

The engine takes 32-bit counter commands from a valid/ready input and applies them to an array of 32-bit counters. Each command names an index and asks for a packet-count increment (+1), a byte-count addition (+data), or both at once. Low indices live in an on-chip word memory that also holds a bank of 64 global registers. High indices are updated in an external memory through a read, add and write-back sequence over a simple request/response port whose response latency varies.

On-chip updates go through a two-stage pipeline: decode and read, then add and write. When one command writes a word and the next command reads that same word, the new value is forwarded, so back-to-back updates of one counter never lose a count. A separate registered read port lets another block copy counter words out. Malformed commands are discarded and tallied in an error counter.

Top module: `stat_update_engine`

## Requirements
- R1: The command word holds the opcode in bits 31:28, the data in bits 27:16 and the index in bits 15:0. For an index i below 128, opcode 0010 adds 1 to on-chip word 128+4i and opcode 0110 adds 1 to word 128+4i+2.
- R2: For an on-chip index i, opcode 0001 adds the 12-bit data, zero-extended, to word 128+4i+1, and opcode 0101 adds it to word 128+4i+3.
- R3: Opcodes 0011 and 0111 perform both updates of their pair (packet word +1 and byte word +data) in a single command.
- R4: Global opcodes address words 0 to 63 directly by index: 1010 adds 1 to word idx, 1001 adds data to word idx, and 1011 adds 1 to word idx and data to word idx+1.
- R5: Every counter wraps modulo 2^32.
- R6: For index i of 128 or more, each selected word at external address EXT_BASE+4(i-128)+offset, with offset 0 to 3 in the group order pre-packet, pre-byte, post-packet, post-byte, is read, its response awaited, and the sum written back to the same address. The packet word is handled before the byte word.
- R7: From the cycle after an external command is accepted, cmd_ready stays low until the final write request has been issued.
- R8: A command is an error if bit 3 is clear and bits 1:0 are zero, if bits 3 and 2 are both set, if it is a global command with index 64 or more, or if it is opcode 1011 at index 63. An error command changes no counter and adds 1 to err_count.
- R9: Commands accepted on consecutive cycles that touch the same on-chip word lose no update.
- R10: copy_data shows the on-chip word at copy_addr one cycle later. Reset clears every on-chip word and err_count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_word | input | 32 | Opcode, data and index |
| copy_addr | input | 10 | Copy-out word address |
| copy_data | output | 32 | Copy-out word, one cycle later |
| ext_req_valid | output | 1 | External request strobe |
| ext_req_we | output | 1 | 1 for a write, 0 for a read |
| ext_req_addr | output | 32 | External word address |
| ext_req_wdata | output | 32 | Write data |
| ext_rsp_valid | input | 1 | Read response strobe |
| ext_rsp_data | input | 32 | Read response data |
| err_count | output | 16 | Count of dropped commands |

## Verification
Single commands of every legal opcode are sent to on-chip pre-queue pairs, post-queue pairs and global words, each followed by a read-back. This separates the packet and byte words and the pre and post pairs, and it shows whether the data field is zero-extended. Bursts with no idle cycles, repeating the same word or alternating the packet and byte words of one pair, show whether forwarding is correct: a missing bypass shows up as a short count. External commands with short and long response latency, and with counters preset near 2^32, check the address arithmetic, the word order, the stall on the input and the wrap-around. A mix of illegal opcodes and out-of-range global indices confirms that such commands are dropped and leave the neighbouring words unchanged.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int CNT_W        = 32;
    localparam int DATA_W       = 12;
    localparam int IDX_W        = 16;
    localparam int GLOBAL_WORDS = 64;
    localparam int FAST_IDX     = 128;
    localparam int GROUP_BASE   = 128;
    localparam int GROUP_WORDS  = 4;
    localparam int MEM_WORDS    = GROUP_BASE + FAST_IDX * GROUP_WORDS;
    localparam int MADDR_W      = $clog2(MEM_WORDS);

    typedef enum logic [1:0] {CK_FAST, CK_EXT, CK_ERR} cmd_kind_e;

    typedef struct packed {
        logic [3:0]        op;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
    } cmd_t;

    typedef struct packed {
        cmd_kind_e          kind;
        logic               en_a;    // packet word: +1
        logic               en_b;    // byte word: +data
        logic [MADDR_W-1:0] addr_a;
        logic [MADDR_W-1:0] addr_b;
        logic [1:0]         off_a;   // offset inside an external group
        logic [1:0]         off_b;
        logic [CNT_W-1:0]   inc_b;
        logic [IDX_W-1:0]   idx;
    } upd_t;

    function automatic logic [CNT_W-1:0] zext_data(input logic [DATA_W-1:0] d);
        return {{(CNT_W-DATA_W){1'b0}}, d};
    endfunction
endpackage

// File: rtl/stat_decode.sv
module stat_decode
    import stat_pkg::*;
(
    input  cmd_t cmd,
    output upd_t upd
);
    localparam logic [IDX_W-1:0]   GLB_LIMIT = IDX_W'(GLOBAL_WORDS);
    localparam logic [IDX_W-1:0]   GLB_LAST  = IDX_W'(GLOBAL_WORDS - 1);
    localparam logic [IDX_W-1:0]   FAST_LIM  = IDX_W'(FAST_IDX);
    localparam logic [MADDR_W-1:0] GBASE     = MADDR_W'(GROUP_BASE);

    logic [MADDR_W-1:0] grp_addr;

    always_comb begin
        grp_addr = GBASE + MADDR_W'({cmd.idx[6:0], 2'b00}) + MADDR_W'({cmd.op[2], 1'b0});
        upd        = '0;
        upd.idx    = cmd.idx;
        upd.inc_b  = zext_data(cmd.data);
        upd.en_a   = cmd.op[1];
        upd.en_b   = cmd.op[0];
        upd.off_a  = {cmd.op[2], 1'b0};
        upd.off_b  = {cmd.op[2], 1'b1};
        if (cmd.op[3]) begin
            upd.addr_a = MADDR_W'(cmd.idx[5:0]);
            upd.addr_b = cmd.op[1] ? MADDR_W'(cmd.idx[5:0]) + MADDR_W'(1) : MADDR_W'(cmd.idx[5:0]);
            if (cmd.op[2] || cmd.op[1:0] == 2'b00 || cmd.idx >= GLB_LIMIT ||
                (cmd.op[1] && cmd.op[0] && cmd.idx == GLB_LAST))
                upd.kind = CK_ERR;
            else
                upd.kind = CK_FAST;
        end else begin
            upd.addr_a = grp_addr;
            upd.addr_b = grp_addr + MADDR_W'(1);
            if (cmd.op[1:0] == 2'b00)   upd.kind = CK_ERR;
            else if (cmd.idx < FAST_LIM) upd.kind = CK_FAST;
            else                        upd.kind = CK_EXT;
        end
        if (upd.kind == CK_ERR) begin
            upd.en_a = 1'b0;
            upd.en_b = 1'b0;
        end
    end
endmodule

// File: rtl/stat_store.sv
module stat_store #(
    parameter int WORDS = 640,
    parameter int AW    = 10,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b,
    input  logic          we_a,
    input  logic [AW-1:0] waddr_a,
    input  logic [DW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] waddr_b,
    input  logic [DW-1:0] wdata_b,
    input  logic [AW-1:0] copy_addr,
    output logic [DW-1:0] copy_data
);
    logic [DW-1:0] mem [WORDS];

    assign rdata_a = (int'(raddr_a) < WORDS) ? mem[raddr_a] : '0;
    assign rdata_b = (int'(raddr_b) < WORDS) ? mem[raddr_b] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            copy_data <= '0;
        end else begin
            if (we_a) mem[waddr_a] <= wdata_a;
            if (we_b) mem[waddr_b] <= wdata_b;
            copy_data <= (int'(copy_addr) < WORDS) ? mem[copy_addr] : '0;
        end
    end

    AST_WR_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_b) |-> (waddr_a != waddr_b)); // R3
endmodule

// File: rtl/stat_ext.sv
module stat_ext
    import stat_pkg::*;
#(
    parameter logic [31:0] EXT_BASE = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  upd_t        upd,
    output logic        busy,
    output logic        req_valid,
    output logic        req_we,
    output logic [31:0] req_addr,
    output logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data
);
    typedef enum logic [1:0] {E_IDLE, E_RD, E_WAIT, E_WR} ext_state_e;

    ext_state_e       state;
    logic [IDX_W-1:0] idx_q;
    logic             has_b, cur_b;
    logic [1:0]       off_a, off_b;
    logic [CNT_W-1:0] inc_b, sum;
    logic [31:0]      rel;

    assign rel       = (32'(idx_q) - 32'(FAST_IDX)) << 2;
    assign busy      = (state != E_IDLE);
    assign req_valid = (state == E_RD) || (state == E_WR);
    assign req_we    = (state == E_WR);
    assign req_addr  = EXT_BASE + rel + 32'(cur_b ? off_b : off_a);
    assign req_wdata = sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= E_IDLE;
            idx_q <= '0;
            has_b <= 1'b0;
            cur_b <= 1'b0;
            off_a <= '0;
            off_b <= '0;
            inc_b <= '0;
            sum   <= '0;
        end else begin
            unique case (state)
                E_IDLE: if (start) begin
                    idx_q <= upd.idx;
                    has_b <= upd.en_b;
                    cur_b <= !upd.en_a;
                    off_a <= upd.off_a;
                    off_b <= upd.off_b;
                    inc_b <= upd.inc_b;
                    state <= E_RD;
                end
                E_RD:   state <= E_WAIT;
                E_WAIT: if (rsp_valid) begin
                    sum   <= rsp_data + (cur_b ? inc_b : CNT_W'(1));
                    state <= E_WR;
                end
                E_WR: begin
                    if (!cur_b && has_b) begin
                        cur_b <= 1'b1;
                        state <= E_RD;
                    end else begin
                        state <= E_IDLE;
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    AST_READ_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we) |=> !req_valid); // R6
    AST_WRITE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we) |-> $past(rsp_valid)); // R6
endmodule

// File: rtl/stat_update_engine.sv
module stat_update_engine
    import stat_pkg::*;
#(
    parameter logic [31:0] EXT_BASE = 32'h0000_1000,
    parameter int          ERR_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [31:0]        cmd_word,
    input  logic [MADDR_W-1:0] copy_addr,
    output logic [CNT_W-1:0]   copy_data,
    output logic               ext_req_valid,
    output logic               ext_req_we,
    output logic [31:0]        ext_req_addr,
    output logic [31:0]        ext_req_wdata,
    input  logic               ext_rsp_valid,
    input  logic [31:0]        ext_rsp_data,
    output logic [ERR_W-1:0]   err_count
);
    upd_t               dec;
    logic               accept, ext_busy;
    logic [CNT_W-1:0]   mem_a, mem_b, cur_a, cur_b;
    logic               s2_v, s2_en_a, s2_en_b;
    logic [MADDR_W-1:0] s2_addr_a, s2_addr_b;
    logic [CNT_W-1:0]   s2_old_a, s2_old_b, s2_inc_b, new_a, new_b;

    stat_decode u_dec (.cmd(cmd_t'(cmd_word)), .upd(dec));

    assign cmd_ready = !ext_busy;
    assign accept    = cmd_valid && cmd_ready;
    assign new_a     = s2_old_a + CNT_W'(1);
    assign new_b     = s2_old_b + s2_inc_b;

    // bypass the word being written this cycle to the command being read
    function automatic logic [CNT_W-1:0] bypass(input logic [MADDR_W-1:0] a,
                                                input logic [CNT_W-1:0] m);
        if (s2_v && s2_en_b && s2_addr_b == a) return new_b;
        if (s2_v && s2_en_a && s2_addr_a == a) return new_a;
        return m;
    endfunction

    assign cur_a = bypass(dec.addr_a, mem_a);
    assign cur_b = bypass(dec.addr_b, mem_b);

    stat_store #(.WORDS(MEM_WORDS), .AW(MADDR_W), .DW(CNT_W)) u_store (
        .clk(clk), .rst(rst),
        .raddr_a(dec.addr_a), .rdata_a(mem_a),
        .raddr_b(dec.addr_b), .rdata_b(mem_b),
        .we_a(s2_v && s2_en_a), .waddr_a(s2_addr_a), .wdata_a(new_a),
        .we_b(s2_v && s2_en_b), .waddr_b(s2_addr_b), .wdata_b(new_b),
        .copy_addr(copy_addr), .copy_data(copy_data)
    );

    stat_ext #(.EXT_BASE(EXT_BASE)) u_ext (
        .clk(clk), .rst(rst),
        .start(accept && dec.kind == CK_EXT), .upd(dec), .busy(ext_busy),
        .req_valid(ext_req_valid), .req_we(ext_req_we),
        .req_addr(ext_req_addr), .req_wdata(ext_req_wdata),
        .rsp_valid(ext_rsp_valid), .rsp_data(ext_rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v      <= 1'b0;
            s2_en_a   <= 1'b0;
            s2_en_b   <= 1'b0;
            s2_addr_a <= '0;
            s2_addr_b <= '0;
            s2_old_a  <= '0;
            s2_old_b  <= '0;
            s2_inc_b  <= '0;
            err_count <= '0;
        end else begin
            s2_v      <= accept && dec.kind == CK_FAST;
            s2_en_a   <= dec.en_a;
            s2_en_b   <= dec.en_b;
            s2_addr_a <= dec.addr_a;
            s2_addr_b <= dec.addr_b;
            s2_old_a  <= cur_a;
            s2_old_b  <= cur_b;
            s2_inc_b  <= dec.inc_b;
            if (accept && dec.kind == CK_ERR) err_count <= err_count + ERR_W'(1);
        end
    end

    AST_EXT_STALLS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.kind == CK_EXT) |=> !cmd_ready); // R7
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> (err_count == $past(err_count) + ERR_W'(1))); // R8
    AST_NO_ERR_ON_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.kind != CK_ERR) |=> (err_count == $past(err_count))); // R8
endmodule

// File: tb/stat_update_engine_tb.sv
module stat_update_engine_tb_top;
    localparam time         CLK_PERIOD = 10ns;
    localparam logic [31:0] BASE       = 32'h0000_1000;
    localparam int          WD_LIMIT   = 20000;

    typedef struct packed {
        logic [31:0] cmd;
        logic [9:0]  addr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // running expectations, starting from reset
    localparam vec_t VEC [11] = '{
        '{32'h2000_0005, 10'd148, 32'd1,    4'd1}, // R1 pre packet
        '{32'h107F_0005, 10'd149, 32'd127,  4'd2}, // R2 pre byte
        '{32'h3FFF_0005, 10'd149, 32'd4222, 4'd3}, // R3 both, data zero-extended
        '{32'h6000_007F, 10'd638, 32'd1,    4'd1}, // R1 post packet
        '{32'h5010_007F, 10'd639, 32'd16,   4'd2}, // R2 post byte
        '{32'h7001_007F, 10'd638, 32'd2,    4'd3}, // R3 post pair
        '{32'hA000_0000, 10'd0,   32'd1,    4'd4}, // R4 global +1
        '{32'h9123_003F, 10'd63,  32'd291,  4'd4}, // R4 global +data
        '{32'hB00A_0010, 10'd17,  32'd10,   4'd4}, // R4 dual, odd word
        '{32'hB005_0010, 10'd16,  32'd2,    4'd4}, // R4 dual, even word
        '{32'h2000_0000, 10'd128, 32'd1,    4'd1}  // R1 index zero
    };

    logic        clk = 0, rst = 1;
    logic        cmd_valid = 0, cmd_ready;
    logic [31:0] cmd_word = '0;
    logic [9:0]  copy_addr = '0;
    logic [31:0] copy_data;
    logic        ext_req_valid, ext_req_we;
    logic [31:0] ext_req_addr, ext_req_wdata;
    logic        ext_rsp_valid = 0;
    logic [31:0] ext_rsp_data = '0;
    logic [15:0] err_count;

    int checks = 0, fails = 0, cyc = 0;
    int ext_lat = 1, ext_cnt = 0;
    bit ext_pend = 0;
    logic [31:0] ext_mem [32];
    logic [31:0] last_rd_addr = '0, first_rd_addr = '0;
    int rd_seen = 0;

    stat_update_engine #(.EXT_BASE(BASE)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .copy_addr(copy_addr), .copy_data(copy_data),
        .ext_req_valid(ext_req_valid), .ext_req_we(ext_req_we),
        .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
        .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data),
        .err_count(err_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // external memory model, acting between edges
    always @(negedge clk) begin
        ext_rsp_valid <= 1'b0;
        if (ext_req_valid && ext_req_we) begin
            ext_mem[5'(ext_req_addr - BASE)] = ext_req_wdata;
        end else if (ext_req_valid) begin
            last_rd_addr = ext_req_addr;
            if (rd_seen == 0) first_rd_addr = ext_req_addr;
            rd_seen++;
            ext_pend = 1;
            ext_cnt  = ext_lat;
        end else if (ext_pend) begin
            ext_cnt--;
            if (ext_cnt <= 0) begin
                ext_pend = 0;
                ext_rsp_valid <= 1'b1;
                ext_rsp_data  <= ext_mem[5'(last_rd_addr - BASE)];
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic send(input logic [31:0] w);
        cmd_word  = w;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cmd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        copy_addr = a;
        @(negedge clk);
        v = copy_data;
    endtask

    task automatic wait_ready();
        while (!cmd_ready) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) ext_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        rd(10'd0, v);   chk(v, 32'd0, "R10 word 0 after reset");
        rd(10'd639, v); chk(v, 32'd0, "R10 word 639 after reset");
        chk(32'(err_count), 32'd0, "R10 err_count after reset");
        chk(32'(cmd_ready), 32'd1, "R10 ready after reset");

        // table walk
        for (int k = 0; k < 11; k++) begin
            send(VEC[k].cmd);
            idle(2);
            rd(VEC[k].addr, v);
            chk(v, VEC[k].exp, $sformatf("R%0d vector %0d", VEC[k].req, k));
        end
        rd(10'd148, v); chk(v, 32'd2, "R3 packet word of pair after both-update");

        // R9 back-to-back hits on one word and on a pair
        send(32'h2000_0001); send(32'h2000_0001); send(32'h2000_0001); send(32'h2000_0001);
        send(32'h3005_0001); send(32'h1007_0001);
        send(32'hB001_0020); send(32'h9002_0021);
        idle(2);
        rd(10'd132, v); chk(v, 32'd5,  "R9 packet word burst");
        rd(10'd133, v); chk(v, 32'd12, "R9 byte word burst");
        rd(10'd33, v);  chk(v, 32'd3,  "R9 global odd word hit twice");
        rd(10'd32, v);  chk(v, 32'd1,  "R9 global even word");

        // R8 error commands
        send(32'h0123_0002); send(32'hC001_0002); send(32'hA000_0040); send(32'hB001_003F);
        idle(2);
        chk(32'(err_count), 32'd4, "R8 error count");
        rd(10'd136, v); chk(v, 32'd0,   "R8 dropped counter untouched");
        rd(10'd63, v);  chk(v, 32'd291, "R8 global 63 untouched");
        rd(10'd64, v);  chk(v, 32'd0,   "R8 reserved word untouched");
        rd(10'd0, v);   chk(v, 32'd1,   "R8 global 0 untouched");

        // R6 R5 R7 external, pre pair of index 128, both words
        ext_mem[0] = 32'hFFFF_FFFF;
        ext_mem[1] = 32'hFFFF_FFF0;
        ext_lat = 1;
        rd_seen = 0;
        send(32'h3020_0080);
        chk(32'(cmd_ready), 32'd0, "R7 ready low after external accept");
        cmd_valid = 1'b0;
        wait_ready();
        chk(ext_mem[0], 32'd0,          "R5 packet wraps");
        chk(ext_mem[1], 32'h0000_0010,  "R5 byte wraps");
        chk(first_rd_addr, BASE,        "R6 packet word read first");
        chk(32'(rd_seen), 32'd2,        "R6 two reads for pair");

        // R6 post byte of index 129, long latency
        ext_mem[7] = 32'd100;
        ext_lat = 6;
        rd_seen = 0;
        send(32'h5003_0081);
        chk(32'(cmd_ready), 32'd0, "R7 ready low during long latency");
        cmd_valid = 1'b0;
        wait_ready();
        chk(last_rd_addr, BASE + 32'd7, "R6 external address");
        chk(ext_mem[7], 32'd103,        "R6 external add");
        rd(10'd639, v); chk(v, 32'd17,  "R6 on-chip word unchanged by external");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule